// File: doc/BRIEF.md
# SPI Register Access Slave

This block lets an SPI host read and write a bank of sixteen 8-bit UART control registers. Each access is framed by one assertion of the active-low select. The first byte on MOSI is a command byte. Its most significant bit gives the direction, the next four bits give the register index, two bits select the channel, and the least significant bit is a don't-care. The second byte is the data byte. On a write, the host shifts that byte in. On a read, the block shifts it out on MISO.

The serial pins are brought into the system clock domain by synchronizer chains. The block shifts bits MSB first in SPI mode 0: it samples MOSI on a rising SCLK edge and moves MISO after a falling edge. On the register side it issues one-cycle read and write strobes together with an address and write data. It takes read data in the same cycle as the read strobe. Only channel 00 reaches the register bank.

Top module: `spi_reg_slave`

## Requirements
- R1: After reset, `reg_we_o`, `reg_re_o`, `miso_oe_o` and `miso_o` are all low.
- R2: In the command byte, bit 7 = 1 means read and 0 means write. Bits 6:3 are the register index. Bits 2:1 are the channel. Bit 0 has no effect on any access.
- R3: A write command with channel 00, followed by eight data bits MSB first, produces exactly one single-cycle `reg_we_o` pulse. During that pulse, `reg_addr_o` holds the command index and `reg_wdata_o` holds the data byte.
- R4: A read command with channel 00 produces one single-cycle `reg_re_o` pulse, with `reg_addr_o` set to the index, after the eighth command bit. `reg_rdata_i` is taken in that cycle. The value is shifted out MSB first on `miso_o`. The first bit is valid before the first data rising edge, and each later bit is valid within four system clocks of a falling SCLK edge.
- R5: A command whose channel field is not 00 produces no strobe. On a read with such a channel, `miso_o` returns 0x00.
- R6: Raising the select before a byte completes aborts the frame with no strobe. The next frame decodes its command from its first bit.
- R7: `miso_oe_o` follows the synchronized select: high while selected, low otherwise. `miso_o` is low whenever `miso_oe_o` is low.
- R8: Bits clocked after the data byte, within the same select, are ignored: each frame gives at most one strobe.
- R9: `reg_we_o` and `reg_re_o` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | SPI serial clock |
| cs_ni | input | 1 | SPI select, active low |
| mosi_i | input | 1 | Serial data from host |
| miso_o | output | 1 | Serial data to host |
| miso_oe_o | output | 1 | Output enable for MISO pad driver |
| reg_we_o | output | 1 | Register write strobe, one cycle |
| reg_re_o | output | 1 | Register read strobe, one cycle |
| reg_addr_o | output | 4 | Register index |
| reg_wdata_o | output | 8 | Register write data |
| reg_rdata_i | input | 8 | Register read data, valid in the read-strobe cycle |

## Verification
The assertions assume that SCLK and the select change slowly compared with the system clock. Every SCLK level and every select level must last longer than the synchronizer latency plus one cycle, so that each edge is seen exactly once and in order. They also assume that the register side presents `reg_rdata_i` combinationally from `reg_addr_o`. The stimulus holds each SCLK phase and each select gap for eight system clocks. It changes MOSI only while SCLK is low. It models the register bank as a combinational array indexed by the address port.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned ADDR_W = 4;
  localparam int unsigned CH_W   = 2;
  localparam int unsigned CNT_W  = $clog2(DATA_W);
  // command byte field positions
  localparam int unsigned CMD_RD_BIT = DATA_W - 1;
  localparam int unsigned CMD_A_HI   = DATA_W - 2;
  localparam int unsigned CMD_A_LO   = CMD_A_HI - ADDR_W + 1;
  localparam int unsigned CMD_C_HI   = CMD_A_LO - 1;
  localparam int unsigned CMD_C_LO   = CMD_C_HI - CH_W + 1;

  typedef enum logic [1:0] {
    PH_CMD  = 2'd0,
    PH_DATA = 2'd1,
    PH_DONE = 2'd2
  } phase_e;
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  input  logic cs_ni,
  input  logic mosi_i,
  output logic sclk_rise_o,
  output logic sclk_fall_o,
  output logic cs_act_o,
  output logic mosi_o
);
  logic [STAGES-1:0] sclk_q, cs_q, mosi_q;
  logic              sclk_d;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          sclk_q[0] <= 1'b0;
          cs_q[0]   <= 1'b1;
          mosi_q[0] <= 1'b0;
        end else begin
          sclk_q[0] <= sclk_i;
          cs_q[0]   <= cs_ni;
          mosi_q[0] <= mosi_i;
        end
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          sclk_q[i] <= 1'b0;
          cs_q[i]   <= 1'b1;
          mosi_q[i] <= 1'b0;
        end else begin
          sclk_q[i] <= sclk_q[i-1];
          cs_q[i]   <= cs_q[i-1];
          mosi_q[i] <= mosi_q[i-1];
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_d <= 1'b0;
    else         sclk_d <= sclk_q[STAGES-1];
  end

  assign sclk_rise_o = sclk_q[STAGES-1] & ~sclk_d;
  assign sclk_fall_o = ~sclk_q[STAGES-1] & sclk_d;
  assign cs_act_o    = ~cs_q[STAGES-1];
  assign mosi_o      = mosi_q[STAGES-1];
endmodule

// File: rtl/spi_bit_engine.sv
module spi_bit_engine
  import spi_reg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              cs_act_i,
  input  logic              mosi_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_data_i,
  output logic              cmd_vld_o,
  output logic              data_vld_o,
  output logic [DATA_W-1:0] rx_byte_o,
  output logic              miso_bit_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  phase_e            phase_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] rx_q, tx_q;
  logic              take;

  assign take = cs_act_i & rise_i & (phase_q != PH_DONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_CMD;
      cnt_q   <= '0;
      rx_q    <= '0;
    end else if (!cs_act_i) begin
      phase_q <= PH_CMD;
      cnt_q   <= '0;
    end else if (take) begin
      rx_q  <= {rx_q[DATA_W-2:0], mosi_i};
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == LAST) begin
        cnt_q   <= '0;
        phase_q <= (phase_q == PH_CMD) ? PH_DATA : PH_DONE;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_vld_o  <= 1'b0;
      data_vld_o <= 1'b0;
    end else begin
      cmd_vld_o  <= take & (cnt_q == LAST) & (phase_q == PH_CMD);
      data_vld_o <= take & (cnt_q == LAST) & (phase_q == PH_DATA);
    end
  end

  // MSB is presented at load; shift only on falls that follow a data bit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                         tx_q <= '0;
    else if (!cs_act_i)                                  tx_q <= '0;
    else if (load_i)                                     tx_q <= load_data_i;
    else if (fall_i && phase_q == PH_DATA && cnt_q != 0) tx_q <= {tx_q[DATA_W-2:0], 1'b0};
  end

  assign rx_byte_o  = rx_q;
  assign miso_bit_o = tx_q[DATA_W-1];
endmodule

// File: rtl/spi_cmd_ctrl.sv
module spi_cmd_ctrl
  import spi_reg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_vld_i,
  input  logic              data_vld_i,
  input  logic [DATA_W-1:0] rx_byte_i,
  output logic              reg_we_o,
  output logic              reg_re_o,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic [DATA_W-1:0] reg_wdata_o
);
  logic cmd_rd_q, ch_ok_q;
  logic ch_ok;

  assign ch_ok = (rx_byte_i[CMD_C_HI:CMD_C_LO] == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_rd_q    <= 1'b0;
      ch_ok_q     <= 1'b0;
      reg_addr_o  <= '0;
      reg_wdata_o <= '0;
      reg_we_o    <= 1'b0;
      reg_re_o    <= 1'b0;
    end else begin
      reg_we_o <= 1'b0;
      reg_re_o <= 1'b0;
      if (cmd_vld_i) begin
        cmd_rd_q   <= rx_byte_i[CMD_RD_BIT];
        ch_ok_q    <= ch_ok;
        reg_addr_o <= rx_byte_i[CMD_A_HI:CMD_A_LO];
        reg_re_o   <= rx_byte_i[CMD_RD_BIT] & ch_ok;
      end
      if (data_vld_i) begin
        reg_wdata_o <= rx_byte_i;
        reg_we_o    <= ~cmd_rd_q & ch_ok_q;
      end
    end
  end
endmodule

// File: rtl/spi_reg_slave.sv
module spi_reg_slave
  import spi_reg_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              cs_ni,
  input  logic              mosi_i,
  output logic              miso_o,
  output logic              miso_oe_o,
  output logic              reg_we_o,
  output logic              reg_re_o,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic [DATA_W-1:0] reg_wdata_o,
  input  logic [DATA_W-1:0] reg_rdata_i
);
  logic rise, fall, cs_act, mosi_s;
  logic cmd_vld, data_vld, miso_bit;
  logic [DATA_W-1:0] rx_byte;

  spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .sclk_i, .cs_ni, .mosi_i,
    .sclk_rise_o(rise), .sclk_fall_o(fall), .cs_act_o(cs_act), .mosi_o(mosi_s)
  );

  spi_bit_engine u_eng (
    .clk_i, .rst_ni,
    .rise_i(rise), .fall_i(fall), .cs_act_i(cs_act), .mosi_i(mosi_s),
    .load_i(reg_re_o), .load_data_i(reg_rdata_i),
    .cmd_vld_o(cmd_vld), .data_vld_o(data_vld),
    .rx_byte_o(rx_byte), .miso_bit_o(miso_bit)
  );

  spi_cmd_ctrl u_ctrl (
    .clk_i, .rst_ni,
    .cmd_vld_i(cmd_vld), .data_vld_i(data_vld), .rx_byte_i(rx_byte),
    .reg_we_o, .reg_re_o, .reg_addr_o, .reg_wdata_o
  );

  assign miso_oe_o = cs_act;
  assign miso_o    = cs_act & miso_bit;
endmodule

// File: rtl/spi_reg_slave_chk.sv
module spi_reg_slave_chk
  import spi_reg_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              miso_o,
  input logic              miso_oe_o,
  input logic              reg_we_o,
  input logic              reg_re_o,
  input logic [DATA_W-1:0] reg_rdata_i
);
  logic [1:0] frame_strobes_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   frame_strobes_q <= '0;
    else if (!miso_oe_o)           frame_strobes_q <= '0;
    else if (reg_we_o || reg_re_o) frame_strobes_q <= frame_strobes_q + 1'b1;
  end

  // R9
  strobe_mutex_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_we_o && reg_re_o));
  // R3
  we_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |=> !reg_we_o);
  // R4
  re_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_re_o |=> !reg_re_o);
  // R4
  read_msb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_re_o |=> (miso_o == $past(reg_rdata_i[DATA_W-1])));
  // R7
  miso_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !miso_oe_o |-> !miso_o);
  // R6
  strobe_selected_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_o || reg_re_o) |-> miso_oe_o);
  // R8
  one_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_o || reg_re_o) |-> (frame_strobes_q == 2'd0));
endmodule

bind spi_reg_slave spi_reg_slave_chk u_chk (
  .clk_i, .rst_ni, .miso_o, .miso_oe_o, .reg_we_o, .reg_re_o, .reg_rdata_i
);

// File: tb/spi_reg_slave_tb.sv
module spi_reg_slave_tb;
  localparam int HALF = 8;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso, miso_oe, we, re;
  logic [3:0] addr;
  logic [7:0] wdata, rdata;
  logic [7:0] regs [16];

  int n_chk = 0, n_err = 0;
  int we_cnt = 0, re_cnt = 0, both_cnt = 0;
  logic [3:0] last_waddr, last_raddr;
  logic [7:0] last_wdata;

  always #2.5 clk = ~clk;

  spi_reg_slave u_dut (
    .clk_i(clk), .rst_ni, .sclk_i(sclk), .cs_ni(cs_n), .mosi_i(mosi),
    .miso_o(miso), .miso_oe_o(miso_oe), .reg_we_o(we), .reg_re_o(re),
    .reg_addr_o(addr), .reg_wdata_o(wdata), .reg_rdata_i(rdata)
  );

  assign rdata = regs[addr];

  initial for (int i = 0; i < 16; i++) regs[i] = 8'(i * 17) ^ 8'hA5;

  always @(negedge clk) begin
    if (we && re) both_cnt++;
    if (we) begin
      we_cnt++; last_waddr = addr; last_wdata = wdata; regs[addr] = wdata;
    end
    if (re) begin re_cnt++; last_raddr = addr; end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] cmd(input logic rd, input logic [3:0] a,
                                     input logic [1:0] ch, input logic b0);
    return {rd, a, ch, b0};
  endfunction

  task automatic frame(input logic [23:0] bits, input int n, output logic [7:0] rd);
    rd = '0;
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      mosi = bits[23-i];
      repeat (HALF) @(negedge clk);
      if (i >= 8 && i < 16) rd = {rd[6:0], miso};
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic t_reset;
    check("R1 we", we, 0);
    check("R1 re", re, 0);
    check("R1 oe", miso_oe, 0);
    check("R1 miso", miso, 0);
  endtask

  task automatic t_write_read;
    logic [7:0] r;
    int w0 = we_cnt, r0 = re_cnt;
    frame({cmd(0, 4'd5, 2'b00, 0), 8'h3C, 8'h00}, 16, r);
    check("R3 one write", we_cnt - w0, 1);
    check("R3 addr", last_waddr, 5);
    check("R3 data", last_wdata, 8'h3C);
    check("R2 write gives no read", re_cnt - r0, 0);
    frame({cmd(1, 4'd5, 2'b00, 0), 8'h00, 8'h00}, 16, r);
    check("R4 one read", re_cnt - r0, 1);
    check("R4 addr", last_raddr, 5);
    check("R4 data", r, 8'h3C);
    frame({cmd(1, 4'd12, 2'b00, 0), 8'h00, 8'h00}, 16, r);
    check("R4 preset data", r, 8'(12 * 17) ^ 8'hA5);
  endtask

  task automatic t_bit0;
    logic [7:0] r;
    int w0 = we_cnt;
    frame({cmd(0, 4'd9, 2'b00, 1), 8'hC3, 8'h00}, 16, r);
    check("R2 bit0 write", we_cnt - w0, 1);
    check("R2 bit0 addr", last_waddr, 9);
    frame({cmd(1, 4'd9, 2'b00, 1), 8'h00, 8'h00}, 16, r);
    check("R2 bit0 read", r, 8'hC3);
  endtask

  task automatic t_channel;
    logic [7:0] r;
    int w0 = we_cnt, r0 = re_cnt;
    frame({cmd(0, 4'd5, 2'b01, 0), 8'hFF, 8'h00}, 16, r);
    check("R5 no write on ch01", we_cnt - w0, 0);
    frame({cmd(1, 4'd12, 2'b10, 0), 8'h00, 8'h00}, 16, r);
    check("R5 no read on ch10", re_cnt - r0, 0);
    check("R5 zero data", r, 8'h00);
    frame({cmd(1, 4'd5, 2'b00, 0), 8'h00, 8'h00}, 16, r);
    check("R5 reg untouched", r, 8'h3C);
  endtask

  task automatic t_abort;
    logic [7:0] r;
    int w0 = we_cnt, r0 = re_cnt;
    frame({cmd(1, 4'd3, 2'b00, 0), 16'h0000}, 4, r);
    check("R6 abort in cmd", (we_cnt - w0) + (re_cnt - r0), 0);
    frame({cmd(0, 4'd7, 2'b00, 0), 8'hF0, 8'h00}, 12, r);
    check("R6 abort in data", we_cnt - w0, 0);
    frame({cmd(0, 4'd2, 2'b00, 0), 8'h81, 8'h00}, 16, r);
    check("R6 fresh frame count", we_cnt - w0, 1);
    check("R6 fresh frame addr", last_waddr, 2);
    check("R6 fresh frame data", last_wdata, 8'h81);
  endtask

  task automatic t_extra;
    logic [7:0] r;
    int w0 = we_cnt;
    frame({cmd(0, 4'd11, 2'b00, 0), 8'h5A, 8'hFF}, 24, r);
    check("R8 single strobe", we_cnt - w0, 1);
    check("R8 data kept", last_wdata, 8'h5A);
  endtask

  task automatic t_oe;
    cs_n = 1'b0;
    repeat (6) @(negedge clk);
    check("R7 oe selected", miso_oe, 1);
    cs_n = 1'b1;
    repeat (6) @(negedge clk);
    check("R7 oe idle", miso_oe, 0);
    check("R7 miso idle", miso, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);
    t_oe();
    t_write_read();
    t_bit0();
    t_channel();
    t_abort();
    t_extra();
    check("R9 strobes never overlap", both_cnt, 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(negedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule